// File: doc/BRIEF.md
# Re-Reference Counter Victim Selector

This block keeps the replacement state for an N-way set-associative cache and picks the way to fill when a miss occurs. Each way of each set has a small saturating counter that estimates how soon the line will be re-referenced. A hit resets that counter to zero. On a miss, the first way whose counter sits at the maximum is evicted. If no counter in the set is at the maximum, every counter in the set steps up together, one step per cycle, until one of them reaches it. Lines that are touched once and never again drift to the maximum and leave first. Lines that are reused keep being pulled back to zero, so they stay.

A per-access mode input switches a miss to a one-bit not-recently-used scheme. In that scheme a single bit per way is cleared on access, and a way whose bit is still set is the candidate for eviction. When the bits do not single out a way, a free-running LFSR supplies the choice. The surrounding cache controller presents one access at a time, a hit or a miss, and waits on `acc_ready`. For a miss it takes the way from `victim_way` in the cycle `victim_valid` is high. Tags, data and the fill path stay outside the block.

Top module: `reref_repl`

## Requirements
- R1: After reset every counter holds its maximum (3 for 2-bit counters) and every not-recently-used bit is set. `acc_ready` is high and `victim_valid` is low.
- R2: An access accepted with `acc_hit`=1 sets the counter of `acc_way` in `acc_set` to 0 and clears that way's not-recently-used bit. It does this in either mode and leaves `acc_ready` high.
- R3: Take a miss accepted with `nru_mode`=0 whose set already has a counter at the maximum. `victim_valid` rises in the first cycle after acceptance, and `victim_way` is the lowest-numbered way at the maximum.
- R4: Take a counter-mode miss whose set has no counter at the maximum. All counters of that set increase by one per cycle until at least one reaches it. `victim_valid` comes k+1 cycles after acceptance, where k is the number of increments, which is at most 3.
- R5: When a counter-mode victim is chosen, its counter is loaded with 2, one below the maximum. The other counters of the set keep their values.
- R6: A miss accepted with `nru_mode`=1 is decided in the first cycle after acceptance. When the set has some bits set and some clear, the victim is the lowest-numbered way whose bit is set. Afterwards the victim's bit is clear and every other bit of that set is set.
- R7: In not-recently-used mode, a set whose bits are all set or all clear takes its victim from the low bits of the LFSR. The decision still comes in the first cycle after acceptance.
- R8: From acceptance of a miss until its decision, `acc_ready` is low, and an access presented in that time is ignored. `victim_valid` lasts exactly one cycle, and `acc_ready` is high in the following cycle.
- R9: Accesses to one set leave the counters and bits of every other set unchanged.
- R10: A hit never raises `victim_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_set | input | $clog2(SETS) | Set index of the access |
| acc_way | input | $clog2(WAYS) | Way that hit (ignored on a miss) |
| nru_mode | input | 1 | 0 = counter scheme, 1 = one-bit scheme for this miss |
| acc_ready | output | 1 | Block idle; an access is taken when this and acc_valid are high |
| victim_valid | output | 1 | One-cycle pulse: victim_way holds the way to fill |
| victim_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
The bench builds the block with 4 sets, 4 ways and 2-bit counters. With 4 ways, one set can be walked through every way at the maximum, every way at 2, and every way at 0. That covers all aging depths from none up to the full three increments. The 4 sets leave room to use one set per scenario and to show that the others stay untouched. Random picks in one-bit mode cannot be predicted without copying the LFSR. For those, the bench checks the timing and then checks the bit pattern left behind, using the deterministic miss that follows.

// File: rtl/reref_pkg.sv
package reref_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_SEARCH
  } reref_state_e;

  // lowest index below n whose bit is set in v (0 if none)
  function automatic int unsigned lowest_set(input logic [63:0] v, input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (i < n && v[i]) idx = i;
    end
    return idx;
  endfunction

  // one step of a counter that stops at m
  function automatic logic [7:0] step_sat(input logic [7:0] v, input logic [7:0] m);
    return (v >= m) ? v : v + 8'd1;
  endfunction

endpackage

// File: rtl/reref_lfsr.sv
module reref_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic fb;

  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/reref_ctr_store.sv
module reref_ctr_store #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  parameter int CW   = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int MAXV  = (1 << CW) - 1,
  localparam int FILLV = MAXV - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SET_W-1:0]   sel_set,
  input  logic               clr_en,
  input  logic [WAY_W-1:0]   clr_way,
  input  logic               age_en,
  input  logic               fill_en,
  input  logic [WAY_W-1:0]   fill_way,
  output logic [WAYS*CW-1:0] rd_ctrs
);
  logic [WAYS*CW-1:0] set_vec [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS*CW-1:0] q;
    logic               hit_me;

    assign hit_me     = (sel_set == SET_W'(s));
    assign set_vec[s] = q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '1;
      end else if (hit_me) begin
        for (int w = 0; w < WAYS; w++) begin
          if (clr_en && clr_way == WAY_W'(w))
            q[w*CW +: CW] <= '0;
          else if (fill_en && fill_way == WAY_W'(w))
            q[w*CW +: CW] <= CW'(FILLV);
          else if (age_en)
            q[w*CW +: CW] <= CW'(reref_pkg::step_sat(8'(q[w*CW +: CW]), 8'(MAXV)));
        end
      end
    end
  end

  assign rd_ctrs = set_vec[sel_set];
endmodule

// File: rtl/reref_nru_store.sv
module reref_nru_store #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] sel_set,
  input  logic             clr_en,
  input  logic [WAY_W-1:0] clr_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAYS-1:0]  rd_bits
);
  logic [WAYS-1:0] set_vec [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0] q;
    logic            hit_me;

    assign hit_me     = (sel_set == SET_W'(s));
    assign set_vec[s] = q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '1;
      end else if (hit_me) begin
        for (int w = 0; w < WAYS; w++) begin
          if (clr_en && clr_way == WAY_W'(w))
            q[w] <= 1'b0;
          else if (fill_en)
            q[w] <= (fill_way != WAY_W'(w));
        end
      end
    end
  end

  assign rd_bits = set_vec[sel_set];
endmodule

// File: rtl/reref_repl.sv
module reref_repl #(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int CW     = 2,
  parameter int LFSR_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int MAXV  = (1 << CW) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             nru_mode,
  output logic             acc_ready,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  import reref_pkg::*;

  reref_state_e        state_q;
  logic [SET_W-1:0]    cur_set_q;
  logic                cur_nru_q;

  // named events
  logic                acc_fire;
  logic                hit_evt;
  logic                miss_evt;
  logic                searching;
  logic                decide_evt;
  logic                age_evt;

  logic [SET_W-1:0]    sel_set;
  logic [WAYS*CW-1:0]  rd_ctrs;
  logic [WAYS-1:0]     rd_bits;
  logic [WAYS-1:0]     ctr_at_max;
  logic                ctr_found;
  logic [WAY_W-1:0]    ctr_pick;
  logic                nru_rand;
  logic [WAY_W-1:0]    nru_pick;
  logic [LFSR_W-1:0]   rnd;

  assign acc_ready  = (state_q == ST_IDLE);
  assign acc_fire   = acc_valid && acc_ready;
  assign hit_evt    = acc_fire && acc_hit;
  assign miss_evt   = acc_fire && !acc_hit;
  assign searching  = (state_q == ST_SEARCH);
  assign sel_set    = searching ? cur_set_q : acc_set;

  for (genvar w = 0; w < WAYS; w++) begin : g_max
    assign ctr_at_max[w] = (rd_ctrs[w*CW +: CW] == CW'(MAXV));
  end

  assign ctr_found = |ctr_at_max;
  assign ctr_pick  = WAY_W'(lowest_set(64'(ctr_at_max), WAYS));
  assign nru_rand  = (&rd_bits) || !(|rd_bits);
  assign nru_pick  = nru_rand ? rnd[WAY_W-1:0]
                              : WAY_W'(lowest_set(64'(rd_bits), WAYS));

  assign decide_evt   = searching && (cur_nru_q || ctr_found);
  assign age_evt      = searching && !cur_nru_q && !ctr_found;
  assign victim_valid = decide_evt;
  assign victim_way   = cur_nru_q ? nru_pick : ctr_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_set_q <= '0;
      cur_nru_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss_evt) begin
          state_q   <= ST_SEARCH;
          cur_set_q <= acc_set;
          cur_nru_q <= nru_mode;
        end
        ST_SEARCH: if (decide_evt) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  reref_ctr_store #(.SETS(SETS), .WAYS(WAYS), .CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_set  (sel_set),
    .clr_en   (hit_evt),
    .clr_way  (acc_way),
    .age_en   (age_evt),
    .fill_en  (decide_evt && !cur_nru_q),
    .fill_way (ctr_pick),
    .rd_ctrs  (rd_ctrs)
  );

  reref_nru_store #(.SETS(SETS), .WAYS(WAYS)) u_nru (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_set  (sel_set),
    .clr_en   (hit_evt),
    .clr_way  (acc_way),
    .fill_en  (decide_evt && cur_nru_q),
    .fill_way (nru_pick),
    .rd_bits  (rd_bits)
  );

  reref_lfsr #(.W(LFSR_W)) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (rnd)
  );
endmodule

// File: rtl/reref_repl_chk.sv
module reref_repl_chk #(
  parameter int CW = 2,
  localparam int MAXV = (1 << CW) - 1
) (
  input logic clk,
  input logic rst_n,
  input logic acc_valid,
  input logic acc_hit,
  input logic acc_ready,
  input logic victim_valid,
  input logic age_evt
);
  logic [7:0] busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_q <= '0;
    else if (acc_ready)      busy_q <= '0;
    else if (busy_q != 8'hFF) busy_q <= busy_q + 8'd1;
  end

  AST_VICTIM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !acc_ready);  // R8
  AST_VICTIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> (!victim_valid && acc_ready));  // R8
  AST_MISS_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !acc_hit) |=> !acc_ready);  // R8
  AST_HIT_NO_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_hit) |=> (!victim_valid && acc_ready));  // R10
  AST_AGING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |-> (busy_q <= 8'(MAXV)));  // R4
  AST_NO_AGE_ON_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
    age_evt |-> (!victim_valid && !acc_ready));  // R4
endmodule

bind reref_repl reref_repl_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_hit      (acc_hit),
  .acc_ready    (acc_ready),
  .victim_valid (victim_valid),
  .age_evt      (age_evt)
);

// File: tb/reref_repl_tb.sv
`timescale 1ns/1ps
module reref_repl_tb;
  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int CW   = 2;
  localparam int NV   = 26;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_hit = 1'b0;
  logic [1:0] acc_set = '0;
  logic [1:0] acc_way = '0;
  logic       nru_mode = 1'b0;
  logic       acc_ready;
  logic       victim_valid;
  logic [1:0] victim_way;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  reref_repl #(.SETS(SETS), .WAYS(WAYS), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_set(acc_set), .acc_way(acc_way), .nru_mode(nru_mode),
    .acc_ready(acc_ready), .victim_valid(victim_valid), .victim_way(victim_way)
  );

  // {nru, hit, set[1:0], way[1:0], exp_way[1:0], exp_lat[2:0]}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,2'd0,2'd0,3'd1},  // R3 all at max -> way 0
    {1'b0,1'b0,2'd0,2'd0,2'd1,3'd1},  // R5 way 0 left at 2
    {1'b0,1'b0,2'd0,2'd0,2'd2,3'd1},
    {1'b0,1'b0,2'd0,2'd0,2'd3,3'd1},
    {1'b0,1'b0,2'd0,2'd0,2'd0,3'd2},  // R4 all at 2 -> one aging step
    {1'b0,1'b1,2'd0,2'd1,2'd0,3'd0},  // R2 hit way 1
    {1'b0,1'b0,2'd0,2'd0,2'd2,3'd1},
    {1'b0,1'b0,2'd0,2'd0,2'd3,3'd1},
    {1'b0,1'b0,2'd0,2'd0,2'd0,3'd2},  // way 1 aged to 1, not at max
    {1'b0,1'b1,2'd0,2'd2,2'd0,3'd0},
    {1'b0,1'b1,2'd0,2'd3,2'd0,3'd0},
    {1'b0,1'b1,2'd0,2'd0,2'd0,3'd0},
    {1'b0,1'b0,2'd0,2'd0,2'd1,3'd3},  // R4 counters 0,1,0,0 -> two steps, way 1
    {1'b0,1'b1,2'd1,2'd0,2'd0,3'd0},
    {1'b0,1'b1,2'd1,2'd1,2'd0,3'd0},
    {1'b0,1'b1,2'd1,2'd2,2'd0,3'd0},
    {1'b0,1'b1,2'd1,2'd3,2'd0,3'd0},
    {1'b0,1'b0,2'd1,2'd0,2'd0,3'd4},  // R4 all zero -> three steps
    {1'b0,1'b0,2'd2,2'd0,2'd0,3'd1},  // R9 set 2 untouched by sets 0 and 1
    {1'b1,1'b1,2'd2,2'd0,2'd0,3'd0},
    {1'b1,1'b1,2'd2,2'd1,2'd0,3'd0},
    {1'b1,1'b0,2'd2,2'd0,2'd2,3'd1},  // R6 bits 0011 -> way 2
    {1'b1,1'b0,2'd2,2'd0,2'd0,3'd1},  // R6 others were set -> way 0
    {1'b1,1'b1,2'd2,2'd1,2'd0,3'd0},
    {1'b1,1'b0,2'd2,2'd0,2'd2,3'd1},  // R6 bits 0011 again
    {1'b0,1'b0,2'd2,2'd0,2'd2,3'd1}   // R9 counters 0,0,3,3 after hits
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives one access; returns cycles to decision (0 for a hit) and the way
  task automatic access(input bit nru, input bit hit, input int s, input int w,
                        output int lat, output int way_o);
    bit busy_ok;
    @(negedge clk);
    nru_mode = nru; acc_hit = hit; acc_set = 2'(s); acc_way = 2'(w); acc_valid = 1'b1;
    @(posedge clk);
    #1 acc_valid = 1'b0;
    lat = 0; way_o = 0;
    if (hit) begin
      @(negedge clk);
      chk(!victim_valid && acc_ready, "R10", int'(victim_valid), 0);
      return;
    end
    busy_ok = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (victim_valid) begin
        lat = c; way_o = int'(victim_way);
        break;
      end
      if (acc_ready) busy_ok = 1'b0;
    end
    chk(busy_ok, "R8", 0, 1);
    @(negedge clk);
    chk(!victim_valid && acc_ready, "R8", int'(victim_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat, way, v1, v2;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_ready == 1'b1, "R1", int'(acc_ready), 1);
    chk(victim_valid == 1'b0, "R1", int'(victim_valid), 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][10], VEC[i][9], int'(VEC[i][8:7]), int'(VEC[i][6:5]), lat, way);
      if (VEC[i][9]) begin
        chk(lat == 0, "R2", lat, 0);
      end else begin
        tag = VEC[i][10] ? "R6" : ((VEC[i][2:0] == 3'd1) ? "R3" : "R4");
        chk(lat == int'(VEC[i][2:0]), tag, lat, int'(VEC[i][2:0]));
        chk(way == int'(VEC[i][4:3]), tag, way, int'(VEC[i][4:3]));
      end
    end

    // R7 set 3 bits all set: random pick, then R6 pattern left behind
    access(1'b1, 1'b0, 3, 0, lat, v1);
    chk(lat == 1, "R7", lat, 1);
    access(1'b1, 1'b0, 3, 0, lat, way);
    chk(way == ((v1 == 0) ? 1 : 0), "R6", way, (v1 == 0) ? 1 : 0);

    // R7 all bits cleared by hits (counters of set 3 also go to 0, R2)
    for (int w = 0; w < WAYS; w++) access(1'b1, 1'b1, 3, w, lat, way);
    access(1'b1, 1'b0, 3, 0, lat, v2);
    chk(lat == 1, "R7", lat, 1);
    access(1'b1, 1'b0, 3, 0, lat, way);
    chk(way == ((v2 == 0) ? 1 : 0), "R6", way, (v2 == 0) ? 1 : 0);

    // R8 a hit on way 0 offered during a long counter search is ignored
    @(negedge clk);
    nru_mode = 1'b0; acc_hit = 1'b0; acc_set = 2'd3; acc_valid = 1'b1;
    @(posedge clk);
    #1 acc_hit = 1'b1; acc_way = 2'd0;
    lat = 0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (victim_valid) begin
        lat = c; way = int'(victim_way);
        break;
      end
    end
    acc_valid = 1'b0;
    chk(lat == 4, "R8", lat, 4);
    chk(way == 0, "R8", way, 0);
    // next counter miss on set 3: way 0 at 2, others at max -> way 1 (R5)
    access(1'b0, 1'b0, 3, 0, lat, way);
    chk(way == 1, "R5", way, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule